// File: doc/BRIEF.md
# Modulo 2^n+1 Fused Multiply-Add Unit

This block evaluates a sum of products plus an addend in the residue ring of modulus 2^n+1, in a single combinational pass. It takes m operand pairs and one addend. Every operand is an (n+1)-bit value from 0 to 2^n, and the value 2^n stands for the residue −1. It returns the fully reduced residue. No product is completed on its own. Each pair is expanded into n-bit partial-product rows whose wrapped-around bits are inverted. The addend becomes a row of its own. All the offsets these rewrites introduce are gathered into one constant row, computed while the design is elaborated.

All rows enter one carry-save array. Each stage in the array feeds its top carry bit, inverted, back into bit zero of the next stage, which is the modular form of the end-around carry. The first stage absorbs the constant row, so its cells reduce to half-adder-like gates. One final modular adder turns the surviving sum and carry vectors into the result.

Setting the dot-product select removes the addend from the sum. The block then returns the plain inner product of the pairs. The result is present in the same cycle as the inputs, and the block holds no state.

Top module: `mfma_unit`

## Requirements
- R1: For legal operands (every X, Y and Z from 0 to 2^n), `res` equals (X0·Y0 + … + X(m−1)·Y(m−1) + Z) mod (2^n+1).
- R2: `res` always lies in the range 0 to 2^n inclusive.
- R3: An X or Y operand equal to 2^n acts as −1. For example, X = Y = 2^n contributes +1.
- R4: An addend Z equal to 2^n acts as −1 when `dot_mode` is 0.
- R5: With `dot_mode` = 1, the value of `z_in` has no effect, and `res` equals the pure inner product of the pairs modulo 2^n+1.
- R6: A pair with X = 0 contributes nothing to the sum. With all X equal to 0, `res` equals the effective addend.
- R7: The block is purely combinational. The same inputs give the same `res` whatever inputs came before.
- R8: Pair i occupies bits [i·(n+1) +: n+1] of `x_ops` and of `y_ops`, and every pair position contributes with equal weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dot_mode | input | 1 | 1: ignore the addend and return the inner product only |
| x_ops | input | M_PAIRS*(N+1) | Packed first operands of the pairs; pair i at bits [i*(N+1) +: N+1] |
| y_ops | input | M_PAIRS*(N+1) | Packed second operands of the pairs, same packing |
| z_in | input | N+1 | Additive operand, 0 to 2^N |
| res | output | N+1 | Residue of the fused sum, 0 to 2^N |

## Verification
The assertions take it for granted that no operand field ever carries a value above 2^n. Such a value has no meaning in the ring and would break the reference comparison, so a separate domain assertion flags any stimulus that strays outside the range. The stimulus keeps within the range because every operand is drawn from 0 to 2^n: an exhaustive sweep per pair position, all 0/2^n combinations, and biased random values that pick 0 and 2^n often. The assertions also assume the output is observed after the inputs settle, and the bench samples half a clock after each change.

// File: rtl/mfma_pkg.sv
package mfma_pkg;

  // Number of n-bit rows each operand pair contributes to the reduction array:
  // n weighted rows, two negation rows and one small offset row.
  function automatic int rows_per_pair(int n);
    return n + 3;
  endfunction

  // Constant row value that cancels every fixed offset in the array:
  // each pair adds (2^n - 1 - n) from its gated rows, and each of the
  // (total_rows - 2) carry-save stages adds +1 through its inverted wrap carry.
  function automatic longint unsigned offset_cancel(int n, int m, int total_rows);
    longint unsigned modv;
    longint unsigned excess;
    modv   = (64'd1 << n) + 64'd1;
    excess = (longint'(m) * ((64'd1 << n) - 64'd1 - longint'(n))
              + longint'(total_rows) - 64'd2) % modv;
    return (modv - excess) % modv;
  endfunction

endpackage

// File: rtl/mfma_pp_gen.sv
module mfma_pp_gen #(
  parameter int N = 4
) (
  input  logic [N:0]           x_op,
  input  logic [N:0]           y_op,
  output logic [(N+3)*N-1:0]   rows_flat
);
  localparam int RPP = N + 3;

  logic [N-1:0] x_lo, y_lo;
  logic         x_top, y_top;

  assign x_lo  = x_op[N-1:0];
  assign x_top = x_op[N];
  assign y_lo  = y_op[N-1:0];
  assign y_top = y_op[N];

  // Row j stands for x_lo * 2^j (mod 2^n+1), plus the fixed offset 2^j - 1.
  // Bits that wrap past 2^n come back inverted in the low j positions.
  function automatic logic [N-1:0] weighted_row(logic [N-1:0] a, logic sel, int j);
    logic [N-1:0] low_ones;
    logic [N-1:0] turned;
    low_ones = {N{1'b1}} >> (N - j);
    turned   = (a << j) | (a >> (N - j));
    return sel ? (turned ^ low_ones) : low_ones;
  endfunction

  // Offsets of the two negation rows plus the (-1)*(-1) term:
  // 2*x_top + 2*y_top + (x_top & y_top).
  function automatic logic [N-1:0] sign_offset(logic xt, logic yt);
    logic [2:0] v;
    v = {1'b0, xt, 1'b0} + {1'b0, yt, 1'b0} + {2'b00, xt & yt};
    return N'(v);
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_wrow
    assign rows_flat[j*N +: N] = weighted_row(x_lo, y_lo[j], j);
  end

  // -y_lo when X is -1, and -x_lo when Y is -1, each as a bitwise complement.
  assign rows_flat[N*N +: N]     = x_top ? ~y_lo : '0;
  assign rows_flat[(N+1)*N +: N] = y_top ? ~x_lo : '0;
  assign rows_flat[(RPP-1)*N +: N] = sign_offset(x_top, y_top);

endmodule

// File: rtl/mfma_csa_const.sv
module mfma_csa_const #(
  parameter int          N     = 4,
  parameter logic [N-1:0] K_ROW = '0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] s,
  output logic [N-1:0] cy
);
  logic [N-1:0] c_raw;

  // The third input is a constant, so each cell collapses to two gates.
  for (genvar i = 0; i < N; i++) begin : g_cell
    if (K_ROW[i]) begin : g_one
      assign s[i]     = ~(a[i] ^ b[i]);
      assign c_raw[i] = a[i] | b[i];
    end else begin : g_zero
      assign s[i]     = a[i] ^ b[i];
      assign c_raw[i] = a[i] & b[i];
    end
  end

  // The top carry is weighted 2^n, which is -1, so it returns inverted at bit 0.
  assign cy = {c_raw[N-2:0], ~c_raw[N-1]};

endmodule

// File: rtl/mfma_csa_row.sv
module mfma_csa_row #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] cy
);
  logic [N-1:0] c_raw;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s[i]     = a[i] ^ b[i] ^ c[i];
    assign c_raw[i] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cy = {c_raw[N-2:0], ~c_raw[N-1]};

endmodule

// File: rtl/mfma_mod_add.sv
module mfma_mod_add #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N:0]   sum
);
  localparam logic [N:0] MODV = (N+1)'((64'd1 << N) + 64'd1);

  // Both inputs are below 2^n, so a single conditional subtraction reduces fully.
  function automatic logic [N:0] fold_sum(logic [N-1:0] p, logic [N-1:0] q);
    logic [N:0] raw;
    raw = {1'b0, p} + {1'b0, q};
    return (raw >= MODV) ? (raw - MODV) : raw;
  endfunction

  assign sum = fold_sum(a, b);

endmodule

// File: rtl/mfma_unit.sv
module mfma_unit #(
  parameter int N       = 4,
  parameter int M_PAIRS = 4
) (
  input  logic                     dot_mode,
  input  logic [M_PAIRS*(N+1)-1:0] x_ops,
  input  logic [M_PAIRS*(N+1)-1:0] y_ops,
  input  logic [N:0]               z_in,
  output logic [N:0]               res
);
  localparam int W   = N + 1;
  localparam int RPP = mfma_pkg::rows_per_pair(N);
  localparam int RV  = M_PAIRS * RPP + 2;   // data rows: pairs, addend, addend offset
  localparam int RT  = RV + 1;              // plus the constant row
  localparam int NST = RV - 1;              // carry-save stages
  localparam longint unsigned KVAL = mfma_pkg::offset_cancel(N, M_PAIRS, RT);
  localparam bit KFIX = (KVAL == (64'd1 << N));
  localparam logic [N-1:0] KROW = KFIX ? {N{1'b1}} : KVAL[N-1:0];

  logic [RV*N-1:0] row_bus;
  logic [N:0]      z_eff;
  logic [N-1:0]    s_vec [NST];
  logic [N-1:0]    c_vec [NST];

  for (genvar p = 0; p < M_PAIRS; p++) begin : g_pair
    mfma_pp_gen #(.N(N)) u_pp (
      .x_op      (x_ops[p*W +: W]),
      .y_op      (y_ops[p*W +: W]),
      .rows_flat (row_bus[p*RPP*N +: RPP*N])
    );
  end

  // Addend: 2^n is -1, written as the all-ones row (-2) plus one in the offset row.
  // When the constant row cannot hold its value, the missing one goes there as well.
  assign z_eff = dot_mode ? '0 : z_in;
  assign row_bus[(RV-2)*N +: N] = z_eff[N] ? {N{1'b1}} : z_eff[N-1:0];
  assign row_bus[(RV-1)*N +: N] = N'(z_eff[N]) + N'(KFIX);

  mfma_csa_const #(.N(N), .K_ROW(KROW)) u_stage0 (
    .a  (row_bus[0 +: N]),
    .b  (row_bus[N +: N]),
    .s  (s_vec[0]),
    .cy (c_vec[0])
  );

  for (genvar g = 1; g < NST; g++) begin : g_stage
    mfma_csa_row #(.N(N)) u_csa (
      .a  (s_vec[g-1]),
      .b  (c_vec[g-1]),
      .c  (row_bus[(g+1)*N +: N]),
      .s  (s_vec[g]),
      .cy (c_vec[g])
    );
  end

  mfma_mod_add #(.N(N)) u_final (
    .a   (s_vec[NST-1]),
    .b   (c_vec[NST-1]),
    .sum (res)
  );

endmodule

// File: rtl/mfma_unit_chk.sv
module mfma_unit_chk #(
  parameter int N       = 4,
  parameter int M_PAIRS = 4
) (
  input logic                     dot_mode,
  input logic [M_PAIRS*(N+1)-1:0] x_ops,
  input logic [M_PAIRS*(N+1)-1:0] y_ops,
  input logic [N:0]               z_in,
  input logic [N:0]               z_eff,
  input logic [N:0]               res
);
  localparam int W = N + 1;
  localparam longint unsigned MODV = (64'd1 << N) + 64'd1;
  localparam logic [N:0] TOPV = (N+1)'(64'd1 << N);

  function automatic bit in_domain();
    bit ok;
    ok = (z_in <= TOPV);
    for (int p = 0; p < M_PAIRS; p++) begin
      if (x_ops[p*W +: W] > TOPV) ok = 1'b0;
      if (y_ops[p*W +: W] > TOPV) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic longint unsigned plain_residue();
    longint unsigned acc;
    acc = longint'(z_eff);
    for (int p = 0; p < M_PAIRS; p++)
      acc += longint'(x_ops[p*W +: W]) * longint'(y_ops[p*W +: W]);
    return acc % MODV;
  endfunction

  function automatic bit all_x_zero();
    bit z;
    z = 1'b1;
    for (int p = 0; p < M_PAIRS; p++)
      if (x_ops[p*W +: W] != '0) z = 1'b0;
    return z;
  endfunction

  always_comb begin
    AST_OPERAND_DOMAIN: assert (in_domain());                                  // R1
    AST_RESULT_IN_RANGE: assert (res <= TOPV);                                 // R2
    if (in_domain()) begin
      AST_RESIDUE_EXACT: assert (longint'(res) == plain_residue());            // R1
      if (all_x_zero())
        AST_ZERO_PRODUCTS: assert (res == z_eff);                              // R6
    end
    if (dot_mode)
      AST_DOT_DROPS_ADDEND: assert (z_eff == '0);                              // R5
  end

endmodule

bind mfma_unit mfma_unit_chk #(.N(N), .M_PAIRS(M_PAIRS)) u_chk (
  .dot_mode (dot_mode),
  .x_ops    (x_ops),
  .y_ops    (y_ops),
  .z_in     (z_in),
  .z_eff    (z_eff),
  .res      (res)
);

// File: tb/mfma_unit_test.sv
`timescale 1ns/1ps
module mfma_unit_test;
  localparam int N  = 4;
  localparam int MP = 4;
  localparam int W  = N + 1;
  localparam int MODV = 17;
  localparam int TOP  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               dm;
  logic [MP*W-1:0]    x_bus, y_bus;
  logic [N:0]         z_bus;
  logic [N:0]         res;

  int xv [MP];
  int yv [MP];
  int zv;
  int dmv;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  mfma_unit #(.N(N), .M_PAIRS(MP)) uut (
    .dot_mode (dm),
    .x_ops    (x_bus),
    .y_ops    (y_bus),
    .z_in     (z_bus),
    .res      (res)
  );

  function automatic int expected();
    int s;
    s = 0;
    for (int p = 0; p < MP; p++) s += xv[p] * yv[p];
    if (dmv == 0) s += zv;
    return s % MODV;
  endfunction

  function automatic int pick_val();
    int r;
    r = int'($urandom_range(0, 7));
    if (r == 0) return 0;
    if (r == 1) return TOP;
    return int'($urandom_range(0, TOP));
  endfunction

  task automatic clear_ops();
    for (int p = 0; p < MP; p++) begin xv[p] = 0; yv[p] = 0; end
    zv = 0; dmv = 0;
  endtask

  task automatic apply();
    @(posedge clk);
    #1;
    for (int p = 0; p < MP; p++) begin
      x_bus[p*W +: W] = W'(xv[p]);
      y_bus[p*W +: W] = W'(yv[p]);
    end
    z_bus = W'(zv);
    dm    = dmv[0];
    @(negedge clk);
  endtask

  task automatic check_val(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic run_vec(string tag);
    apply();
    check_val(tag, int'(res), expected());
  endtask

  initial begin
    x_bus = '0; y_bus = '0; z_bus = '0; dm = 1'b0;
    clear_ops();

    // Initial state with all operands zero: R6
    run_vec("R6 all-zero");

    // Exhaustive single-pair sweep at each pair position (R1, R3, R4, R8)
    for (int p = 0; p < MP; p++)
      for (int a = 0; a <= TOP; a++)
        for (int b = 0; b <= TOP; b++)
          for (int c = 0; c <= TOP; c++) begin
            clear_ops();
            xv[p] = a; yv[p] = b; zv = c;
            if (p > 0)                      run_vec("R8 pair position");
            else if (c == TOP)              run_vec("R4 addend -1");
            else if (a == TOP || b == TOP)  run_vec("R3 operand -1");
            else                            run_vec("R1 single pair");
          end

    // Every 0 / 2^n combination over all nine operands: R3
    for (int mask = 0; mask < 512; mask++) begin
      for (int p = 0; p < MP; p++) begin
        xv[p] = mask[2*p]   ? TOP : 0;
        yv[p] = mask[2*p+1] ? TOP : 0;
      end
      zv = mask[8] ? TOP : 0;
      dmv = 0;
      run_vec("R3 corner");
    end

    // Biased random vectors: R1 value, R2 range
    for (int k = 0; k < 100000; k++) begin
      for (int p = 0; p < MP; p++) begin xv[p] = pick_val(); yv[p] = pick_val(); end
      zv = pick_val(); dmv = 0;
      run_vec("R1 random");
      check_val("R2 range", (int'(res) <= TOP) ? 1 : 0, 1);
    end

    // Dot-product mode: addend must have no effect: R5
    for (int k = 0; k < 2000; k++) begin
      for (int p = 0; p < MP; p++) begin xv[p] = pick_val(); yv[p] = pick_val(); end
      zv = pick_val(); dmv = 1;
      run_vec("R5 dot mode");
    end

    // One pair with X = 0 contributes nothing: R6
    for (int k = 0; k < 2000; k++) begin
      for (int p = 0; p < MP; p++) begin xv[p] = pick_val(); yv[p] = pick_val(); end
      xv[int'($urandom_range(0, MP-1))] = 0;
      zv = pick_val(); dmv = 0;
      run_vec("R6 zero pair");
    end

    // No memory of earlier inputs: R7
    begin
      int first;
      clear_ops();
      xv[0] = 3; yv[0] = 7; xv[2] = TOP; yv[2] = 5; zv = 9;
      apply();
      first = int'(res);
      check_val("R7 first", first, expected());
      clear_ops();
      for (int p = 0; p < MP; p++) begin xv[p] = TOP; yv[p] = 11; end
      zv = TOP;
      run_vec("R7 other");
      clear_ops();
      xv[0] = 3; yv[0] = 7; xv[2] = TOP; yv[2] = 5; zv = 9;
      apply();
      check_val("R7 repeat", int'(res), first);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule